// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Receiver

This block watches the inbound memory-request path of a root port for message-signalled interrupt writes. A single dword address, supplied on a configuration input, serves as the doorbell. When a four-byte write lands exactly on that address, the block reads the payload as a vector number. It then inverts the output line for that vector in a bank of per-vector level lines. Logic downstream detects an interrupt by watching for a change of level on its line, not for a pulse.

Writes that reach the doorbell but are malformed raise a one-cycle error pulse with a cause code. A malformed write has either the wrong byte count or a vector number outside the allocated range. A live allocation-limit input sets the allocated range. Reads that fall inside the doorbell dword are acknowledged with all-zero data and the requested length echoed. Requests to any other address are left to other agents and have no effect here.

Top module: `msi_doorbell_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, every bit of `vec_level` is 0, `err_pulse` is 0, `err_kind` is 2'b00 and `rd_ack` is 0.
- R2: A write whose address equals `bell_addr` in every bit, with `req_len` = 4 and an allocated vector number, inverts exactly that one bit of `vec_level` at the rising edge that samples `req_wr` high. All other bits stay as they were.
- R3: The payload is little-endian. `req_wdata[7:0]` holds the lowest-address byte and is the least significant byte of the 32-bit vector number, so payload 32'h0000_0100 names vector 256.
- R4: A write whose address differs from `bell_addr` in any bit, including the two low bits, changes no line and raises no error. While no write strobe is present, `vec_level` holds.
- R5: A write to `bell_addr` with `req_len` other than 4 changes no line and raises `err_pulse` with `err_kind` = 2'b01.
- R6: A write to `bell_addr` with length 4 whose vector number is not below both `vec_limit` and NUM_VEC changes no line and raises `err_pulse` with `err_kind` = 2'b10.
- R7: `err_pulse` is high for exactly the one cycle after the rejected write's sampling edge. `err_kind` is 2'b00 whenever `err_pulse` is low.
- R8: A read whose address matches `bell_addr` in bits above bit 1 sets `rd_ack` for one cycle after its sampling edge, with `rd_data` all zero and `rd_len` equal to the requested `req_len`. A read elsewhere sets no `rd_ack`.
- R9: A second valid write of the same vector returns its line to the previous level.
- R10: `vec_limit` is sampled with each write, so lowering it makes a vector that was accepted before fail with the R6 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bell_addr | input | ADDR_W (64) | Doorbell address |
| vec_limit | input | LIM_W (7) | Number of allocated vectors |
| req_addr | input | ADDR_W (64) | Request byte address |
| req_len | input | LEN_W (12) | Request length in bytes |
| req_wdata | input | 32 | Write payload, lowest-address byte in bits 7:0 |
| req_wr | input | 1 | Write strobe, one cycle per request |
| req_rd | input | 1 | Read strobe, one cycle per request |
| rd_ack | output | 1 | Doorbell read answered |
| rd_len | output | LEN_W (12) | Length of the answered read |
| rd_data | output | 32 | Read data, always zero |
| vec_level | output | NUM_VEC (64) | Per-vector level lines |
| err_pulse | output | 1 | Rejected doorbell write |
| err_kind | output | 2 | Cause: 01 bad length, 10 unallocated vector |

## Verification
Each result has one register between the strobe and the port. Line toggles, error pulses and read acknowledges therefore all appear after the rising edge that samples the strobe. The bench drives a request on a falling edge and removes it on the next falling edge. It compares the outputs at that second falling edge, half a cycle after they change. For rejected writes and reads, the bench samples again one cycle later to confirm that `err_pulse` and `rd_ack` have dropped and the lines have held.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int unsigned DWORD_BYTES = 4;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_LEN  = 2'b01,
    ERR_VEC  = 2'b10
  } msi_err_e;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] bell_addr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic              req_rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  localparam int unsigned DW_LSB = 2;

  logic exact_eq;
  logic dword_eq;

  always_comb begin
    exact_eq = (req_addr == bell_addr);
    dword_eq = (req_addr[ADDR_W-1:DW_LSB] == bell_addr[ADDR_W-1:DW_LSB]);
    wr_hit   = req_wr & exact_eq;
    rd_hit   = req_rd & dword_eq;
  end
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_VEC = 64,
  parameter int unsigned LEN_W   = 12,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC),
  localparam int unsigned LIM_W  = $clog2(NUM_VEC + 1)
) (
  input  logic               wr_hit,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [31:0]        req_wdata,
  input  logic [LIM_W-1:0]   vec_limit,
  output logic [NUM_VEC-1:0] tog_mask,
  output msi_err_e           err_next
);
  logic [31:0]      vec_num;
  logic [IDX_W-1:0] vec_idx;
  logic             len_ok;
  logic             below_bank;
  logic             below_limit;
  logic             fire;

  always_comb begin
    vec_num     = {req_wdata[31:24], req_wdata[23:16], req_wdata[15:8], req_wdata[7:0]};
    vec_idx     = vec_num[IDX_W-1:0];
    len_ok      = (req_len == LEN_W'(DWORD_BYTES));
    below_bank  = (vec_num < 32'(NUM_VEC));
    below_limit = (LIM_W'(vec_idx) < vec_limit);
    fire        = wr_hit & len_ok & below_bank & below_limit;
    if (!wr_hit)        err_next = ERR_NONE;
    else if (!len_ok)   err_next = ERR_LEN;
    else if (!fire)     err_next = ERR_VEC;
    else                err_next = ERR_NONE;
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_mask
    assign tog_mask[i] = fire & (vec_idx == IDX_W'(i));
  end
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int unsigned NUM_VEC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] tog_mask,
  output logic [NUM_VEC-1:0] vec_level
);
  logic [NUM_VEC-1:0] lvl_q;
  logic [NUM_VEC-1:0] lvl_d;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_line
    always_comb begin
      lvl_d[i] = lvl_q[i] ^ tog_mask[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i] <= 1'b0;
      end else if (tog_mask[i]) begin
        lvl_q[i] <= lvl_d[i];
      end
    end
  end

  assign vec_level = lvl_q;

  // R2: the decoder requests at most one line per write
  assert_mask_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tog_mask));

  // R2: no more than one line changes at any edge
  assert_single_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_q ^ $past(lvl_q)) <= 1);
endmodule

// File: rtl/msi_rd_resp.sv
module msi_rd_resp #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic [LEN_W-1:0] req_len,
  output logic             rd_ack,
  output logic [LEN_W-1:0] rd_len,
  output logic [31:0]      rd_data
);
  logic             ack_q;
  logic             ack_d;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    ack_d = rd_hit;
    len_d = req_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      len_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (rd_hit) begin
        len_q <= len_d;
      end
    end
  end

  assign rd_ack  = ack_q;
  assign rd_len  = len_q;
  assign rd_data = '0;

  // R8: an acknowledge always answers a doorbell read of the previous cycle
  assert_ack_follows_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(rd_hit));
endmodule

// File: rtl/msi_doorbell_rx.sv
module msi_doorbell_rx
  import msi_rx_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned NUM_VEC = 64,
  localparam int unsigned LIM_W  = $clog2(NUM_VEC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bell_addr,
  input  logic [LIM_W-1:0]   vec_limit,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [31:0]        req_wdata,
  input  logic               req_wr,
  input  logic               req_rd,
  output logic               rd_ack,
  output logic [LEN_W-1:0]   rd_len,
  output logic [31:0]        rd_data,
  output logic [NUM_VEC-1:0] vec_level,
  output logic               err_pulse,
  output logic [1:0]         err_kind
);
  logic               wr_hit;
  logic               rd_hit;
  logic [NUM_VEC-1:0] tog_mask;
  msi_err_e           err_next;
  msi_err_e           err_q;
  msi_err_e           err_d;
  logic               errp_q;
  logic               errp_d;

  msi_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .bell_addr (bell_addr),
    .req_addr  (req_addr),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit)
  );

  msi_vec_decode #(.NUM_VEC(NUM_VEC), .LEN_W(LEN_W)) u_decode (
    .wr_hit    (wr_hit),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .vec_limit (vec_limit),
    .tog_mask  (tog_mask),
    .err_next  (err_next)
  );

  msi_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .tog_mask  (tog_mask),
    .vec_level (vec_level)
  );

  msi_rd_resp #(.LEN_W(LEN_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hit  (rd_hit),
    .req_len (req_len),
    .rd_ack  (rd_ack),
    .rd_len  (rd_len),
    .rd_data (rd_data)
  );

  always_comb begin
    err_d  = err_next;
    errp_d = (err_next != ERR_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= ERR_NONE;
      errp_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      errp_q <= errp_d;
    end
  end

  assign err_pulse = errp_q;
  assign err_kind  = err_q;

  // R4: lines hold whenever no write was strobed
  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_wr) |-> (vec_level == $past(vec_level)));

  // R5 and R6: a rejected write leaves every line alone
  assert_err_no_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (vec_level == $past(vec_level)));

  // R7: an error only follows a write strobe
  assert_err_after_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_wr));

  // R7: cause code is a single bit and only present with the pulse
  assert_err_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_kind) && (!err_pulse -> (err_kind == 2'b00)));
endmodule

// File: tb/msi_doorbell_rx_bench.sv
module msi_doorbell_rx_bench;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned LEN_W   = 12;
  localparam int unsigned NUM_VEC = 64;
  localparam int unsigned LIM_W   = $clog2(NUM_VEC + 1);
  localparam logic [ADDR_W-1:0] BELL = 64'h0000_00FE_DCBA_0040;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [ADDR_W-1:0]  bell_addr;
  logic [LIM_W-1:0]   vec_limit;
  logic [ADDR_W-1:0]  req_addr;
  logic [LEN_W-1:0]   req_len;
  logic [31:0]        req_wdata;
  logic               req_wr;
  logic               req_rd;
  logic               rd_ack;
  logic [LEN_W-1:0]   rd_len;
  logic [31:0]        rd_data;
  logic [NUM_VEC-1:0] vec_level;
  logic               err_pulse;
  logic [1:0]         err_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [NUM_VEC-1:0] exp_lvl;

  always #10 clk = ~clk;

  msi_doorbell_rx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_VEC(NUM_VEC)) u_msi_doorbell_rx (
    .clk(clk), .rst_n(rst_n), .bell_addr(bell_addr), .vec_limit(vec_limit),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_wr(req_wr), .req_rd(req_rd), .rd_ack(rd_ack), .rd_len(rd_len),
    .rd_data(rd_data), .vec_level(vec_level), .err_pulse(err_pulse), .err_kind(err_kind)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive a write for one cycle, model the expected outcome, check at the next falling edge
  task automatic send_wr(string tag, logic [ADDR_W-1:0] a, logic [LEN_W-1:0] l, logic [31:0] d);
    logic [1:0] ek;
    ek = 2'b00;
    if (a == BELL) begin
      if (l != 4) ek = 2'b01;
      else if (d < NUM_VEC && d < 32'(vec_limit)) exp_lvl[d[5:0]] = ~exp_lvl[d[5:0]];
      else ek = 2'b10;
    end
    @(negedge clk);
    req_addr = a; req_len = l; req_wdata = d; req_wr = 1'b1;
    @(negedge clk);
    req_wr = 1'b0;
    chk({tag, " lines"}, 64'(vec_level), 64'(exp_lvl));
    chk({tag, " err"}, 64'(err_pulse), 64'(ek != 2'b00));
    chk({tag, " kind"}, 64'(err_kind), 64'(ek));
    if (ek != 2'b00) begin
      @(negedge clk);
      chk({tag, " R7 pulse drop"}, 64'(err_pulse), 64'd0);
      chk({tag, " R7 kind clear"}, 64'(err_kind), 64'd0);
      chk({tag, " R7 lines hold"}, 64'(vec_level), 64'(exp_lvl));
    end
  endtask

  task automatic t_reset;
    chk("R1 lines", 64'(vec_level), 64'd0);
    chk("R1 err", 64'(err_pulse), 64'd0);
    chk("R1 kind", 64'(err_kind), 64'd0);
    chk("R1 ack", 64'(rd_ack), 64'd0);
  endtask

  task automatic t_toggle;
    vec_limit = 7'd64;
    send_wr("R2 vec5", BELL, 12'd4, 32'd5);
    send_wr("R2 vec0", BELL, 12'd4, 32'd0);
    send_wr("R2 vec63", BELL, 12'd4, 32'd63);
  endtask

  task automatic t_retoggle;
    send_wr("R9 vec5 again", BELL, 12'd4, 32'd5);
    send_wr("R9 vec63 again", BELL, 12'd4, 32'd63);
  endtask

  task automatic t_endian;
    send_wr("R3 0x100", BELL, 12'd4, 32'h0000_0100);
    send_wr("R3 0x21", BELL, 12'd4, 32'h0000_0021);
    send_wr("R3 high byte", BELL, 12'd4, 32'h0100_0000);
  endtask

  task automatic t_addr_miss;
    send_wr("R4 low bit", BELL + 64'd1, 12'd4, 32'd7);
    send_wr("R4 next dword", BELL + 64'd4, 12'd4, 32'd7);
    send_wr("R4 high bit", BELL ^ (64'd1 << 40), 12'd4, 32'd7);
    repeat (3) @(negedge clk);
    chk("R4 idle hold", 64'(vec_level), 64'(exp_lvl));
  endtask

  task automatic t_len;
    send_wr("R5 len2", BELL, 12'd2, 32'd9);
    send_wr("R5 len8", BELL, 12'd8, 32'd9);
    send_wr("R5 len0", BELL, 12'd0, 32'd9);
  endtask

  task automatic t_range;
    vec_limit = 7'd16;
    send_wr("R6 at limit", BELL, 12'd4, 32'd16);
    send_wr("R6 below limit", BELL, 12'd4, 32'd15);
    vec_limit = 7'd64;
    send_wr("R6 at bank size", BELL, 12'd4, 32'd64);
    vec_limit = 7'd100;
    send_wr("R6 limit above bank", BELL, 12'd4, 32'd64);
    send_wr("R6 top vector", BELL, 12'd4, 32'd63);
  endtask

  task automatic t_live_limit;
    vec_limit = 7'd64;
    send_wr("R10 vec5 allowed", BELL, 12'd4, 32'd5);
    vec_limit = 7'd4;
    send_wr("R10 vec5 now refused", BELL, 12'd4, 32'd5);
    send_wr("R10 vec3 allowed", BELL, 12'd4, 32'd3);
    vec_limit = 7'd64;
  endtask

  task automatic t_read;
    @(negedge clk);
    req_addr = BELL + 64'd2; req_len = 12'd3; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    chk("R8 ack", 64'(rd_ack), 64'd1);
    chk("R8 data zero", 64'(rd_data), 64'd0);
    chk("R8 len", 64'(rd_len), 64'd3);
    chk("R8 lines hold", 64'(vec_level), 64'(exp_lvl));
    @(negedge clk);
    chk("R8 ack drop", 64'(rd_ack), 64'd0);
    req_addr = BELL; req_len = 12'd4; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    chk("R8 aligned ack", 64'(rd_ack), 64'd1);
    chk("R8 aligned len", 64'(rd_len), 64'd4);
    req_addr = BELL + 64'd4; req_rd = 1'b1;
    @(negedge clk);
    req_rd = 1'b0;
    chk("R8 miss no ack", 64'(rd_ack), 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; bell_addr = BELL; vec_limit = 7'd64;
    req_addr = '0; req_len = '0; req_wdata = '0; req_wr = 1'b0; req_rd = 1'b0;
    exp_lvl = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_toggle;
    t_retoggle;
    t_endian;
    t_addr_miss;
    t_len;
    t_range;
    t_live_limit;
    t_read;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule